// File: doc/BRIEF.md
# Width-converting dual-clock FIFO

This block moves 36-bit long words from one clock domain to another. The writer stores a whole long word on each accepted edge of `clk_a`. The reader runs on `clk_b` and unloads each long word at a width chosen by `rd_width`:

- the whole word at once;
- two 18-bit halves;
- four 9-bit bytes.

Pieces always leave lowest bits first. A long word's storage slot is given back to the writer only when its final piece has been taken out of memory. Partial unloading therefore never frees space.

Both pointers cross the clock boundary in Gray code through two-stage synchronisers. The writer sees `wr_open` (high means space is free). The reader sees `rd_flag`, whose meaning depends on `fwft_mode`:

- In standard mode, `rd_flag` means "data stored" (not empty), and `rd_data` changes only on a read.
- In fall-through mode, `rd_flag` means "`rd_data` currently holds a valid piece". The next piece is placed there without a request.

`fwft_mode` and `rd_width` are expected to change only while `rst` is high. `DEPTH` must be a power of two, 4 or more.

Top module: `bmf_fifo`

## Requirements
- R1: While `rst` is high at rising edges of both clocks, the block clears itself. Afterwards `wr_open`=1, `rd_flag`=0 and `rd_data`=0, and the sub-word position restarts at the lowest piece.
- R2: A long word is stored on a rising `clk_a` edge only when all of these hold: `wr_cs_n`=0, `wr_dir`=1, `wr_en`=1 and `wr_open`=1. Any other combination stores nothing.
- R3: `wr_open` falls on the same `clk_a` edge as the write that takes the last free slot. Write attempts while `wr_open`=0 leave the stored contents unchanged.
- R4: Long words leave in the order they were written, with no loss and no duplication. The number of stored, unfreed long words never exceeds `DEPTH`.
- R5: `rd_width` encoding and piece placement are as follows:
  - 0: one 36-bit piece.
  - 1: two 18-bit pieces on `rd_data[17:0]`.
  - 2: four 9-bit pieces on `rd_data[8:0]`.
  - 3: treated as 0.
  - Unused upper `rd_data` bits read 0. Pieces go out from bit 0 upward.
- R6: A slot is freed only by the `clk_b` edge that loads the last piece of its long word into `rd_data`. Earlier pieces keep `wr_open` low. After the freeing edge, `wr_open` rises on the third rising `clk_a` edge, or one edge later depending on clock phase.
- R7: Standard mode (`fwft_mode`=0): `rd_flag` is high while at least one long word is stored. A `clk_b` edge with `rd_cs_n`=0, `rd_en`=1 and `rd_flag`=1 loads the next piece into `rd_data`.
- R8: Fall-through mode (`fwft_mode`=1): the next piece appears in `rd_data` with `rd_flag`=1 without a request. A request (`rd_cs_n`=0, `rd_en`=1) on a `clk_b` edge consumes it. `rd_data` holds while `rd_flag`=1 and no request is made. With `rd_width`=0 the output register holds one extra long word, so capacity is `DEPTH`+1.
- R9: In standard mode, read requests while `rd_flag`=0 leave `rd_data` unchanged and lose no piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, sampled by both clocks |
| fwft_mode | input | 1 | 1 = fall-through, 0 = standard |
| wr_cs_n | input | 1 | Write port select, active low |
| wr_dir | input | 1 | 1 = write direction |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Long word to store |
| wr_open | output | 1 | High when a slot is free |
| rd_width | input | 2 | Read piece width code |
| rd_cs_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Output register holding the current piece |
| rd_flag | output | 1 | Not-empty (standard) or output-valid (fall-through) |

## Verification
Each result has a known due time:

- `wr_open` must fall on the very `clk_a` edge of the filling write, so the bench samples it at the following falling edge.
- In standard mode, a read's piece is due on the requesting `clk_b` edge and is sampled at the next falling `clk_b` edge.
- In fall-through mode, the piece is compared before the request is made.
- The space release crosses two synchronising stages plus the flag register. It is checked as "still low" over eight `clk_a` cycles after non-final pieces, and as "high within five falling `clk_a` edges" after the freeing read.
- Empty-side checks wait several `clk_b` cycles so that the pointer crossing has settled.

// File: rtl/bmf_pkg.sv
`timescale 1ns/1ps
package bmf_pkg;
    localparam int LONG_W = 36;
    localparam int HALF_W = 18;
    localparam int BYTE_W = 9;

    typedef logic [LONG_W-1:0] long_t;

    typedef enum logic [1:0] {
        PW_LONG  = 2'd0,
        PW_HALF  = 2'd1,
        PW_QUART = 2'd2,
        PW_ALT   = 2'd3
    } port_width_e;

    // index of the final piece of a long word for a given read width
    function automatic logic [1:0] last_index(port_width_e pw);
        case (pw)
            PW_HALF:  return 2'd1;
            PW_QUART: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

    // extract piece idx of a long word, right aligned, upper bits zero
    function automatic long_t select_piece(long_t w, port_width_e pw, logic [1:0] idx);
        long_t r;
        r = '0;
        case (pw)
            PW_HALF:  r[HALF_W-1:0] = w[int'(idx[0])*HALF_W +: HALF_W];
            PW_QUART: r[BYTE_W-1:0] = w[int'(idx)*BYTE_W +: BYTE_W];
            default:  r = w;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bmf_sync.sv
`timescale 1ns/1ps
module bmf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            q       <= '0;
        end else begin
            stage_q <= d;
            q       <= stage_q;
        end
    end
endmodule

// File: rtl/bmf_wr_ctl.sv
`timescale 1ns/1ps
module bmf_wr_ctl #(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [AW:0] rd_gray_s,
    output logic        open,
    output logic        fire,
    output logic [AW:0] ptr,
    output logic [AW:0] gray
);
    logic [AW:0] ptr_d;
    logic [AW:0] gray_d;
    logic [AW:0] full_match;
    logic        full_q;

    assign fire       = req & ~full_q;
    assign ptr_d      = ptr + {{AW{1'b0}}, fire};
    assign gray_d     = ptr_d ^ (ptr_d >> 1);
    assign full_match = {~rd_gray_s[AW:AW-1], rd_gray_s[AW-2:0]};
    assign open       = ~full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            gray   <= '0;
            full_q <= 1'b0;
        end else begin
            ptr    <= ptr_d;
            gray   <= gray_d;
            full_q <= (gray_d == full_match);
        end
    end
endmodule

// File: rtl/bmf_rd_ctl.sv
`timescale 1ns/1ps
module bmf_rd_ctl
    import bmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fwft,
    input  port_width_e pw,
    input  logic        req,
    input  logic [AW:0] wr_gray_s,
    input  long_t       mem_word,
    output logic [AW-1:0] addr,
    output logic [AW:0] gray,
    output logic [1:0]  sub_idx,
    output long_t       dout,
    output logic        flag
);
    logic [AW:0] ptr_q;
    logic [AW:0] ptr_d;
    logic [1:0]  idx_d;
    logic        ovalid_q;
    logic        avail;
    logic        take;
    logic        fetch;
    logic        last;

    assign avail = (gray != wr_gray_s);
    assign last  = (sub_idx == last_index(pw));
    assign addr  = ptr_q[AW-1:0];

    always_comb begin
        if (fwft) begin
            take  = req & ovalid_q;
            fetch = avail & (~ovalid_q | take);
        end else begin
            take  = req & avail;
            fetch = take;
        end
        idx_d = fetch ? (last ? 2'd0 : sub_idx + 2'd1) : sub_idx;
        ptr_d = ptr_q + {{AW{1'b0}}, fetch & last};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            gray     <= '0;
            sub_idx  <= 2'd0;
            dout     <= '0;
            ovalid_q <= 1'b0;
        end else begin
            ptr_q    <= ptr_d;
            gray     <= ptr_d ^ (ptr_d >> 1);
            sub_idx  <= idx_d;
            if (fetch) dout <= select_piece(mem_word, pw, sub_idx);
            ovalid_q <= fwft & (fetch | (ovalid_q & ~take));
        end
    end

    assign flag = fwft ? ovalid_q : avail;
endmodule

// File: rtl/bmf_fifo.sv
`timescale 1ns/1ps
module bmf_fifo
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk_a,
    input  logic        clk_b,
    input  logic        rst,
    input  logic        fwft_mode,
    input  logic        wr_cs_n,
    input  logic        wr_dir,
    input  logic        wr_en,
    input  logic [35:0] wr_data,
    output logic        wr_open,
    input  logic [1:0]  rd_width,
    input  logic        rd_cs_n,
    input  logic        rd_en,
    output logic [35:0] rd_data,
    output logic        rd_flag
);
    localparam int AW = $clog2(DEPTH);

    long_t       mem [DEPTH];
    logic        wr_req;
    logic        wr_fire;
    logic [AW:0] wr_ptr;
    logic [AW:0] wr_gray;
    logic [AW:0] wr_gray_b;
    logic [AW:0] rd_gray;
    logic [AW:0] rd_gray_a;
    logic [AW-1:0] rd_addr;
    logic [1:0]  sub_idx;
    logic        rd_req;
    port_width_e pw;

    assign wr_req = ~wr_cs_n & wr_dir & wr_en;
    assign rd_req = ~rd_cs_n & rd_en;
    assign pw     = port_width_e'(rd_width);

    always_ff @(posedge clk_a) begin
        if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    bmf_wr_ctl #(.AW(AW)) u_wr (
        .clk(clk_a), .rst(rst), .req(wr_req), .rd_gray_s(rd_gray_a),
        .open(wr_open), .fire(wr_fire), .ptr(wr_ptr), .gray(wr_gray)
    );

    bmf_sync #(.W(AW+1)) u_sync_rd2wr (
        .clk(clk_a), .rst(rst), .d(rd_gray), .q(rd_gray_a)
    );

    bmf_sync #(.W(AW+1)) u_sync_wr2rd (
        .clk(clk_b), .rst(rst), .d(wr_gray), .q(wr_gray_b)
    );

    bmf_rd_ctl #(.AW(AW)) u_rd (
        .clk(clk_b), .rst(rst), .fwft(fwft_mode), .pw(pw), .req(rd_req),
        .wr_gray_s(wr_gray_b), .mem_word(mem[rd_addr]), .addr(rd_addr),
        .gray(rd_gray), .sub_idx(sub_idx), .dout(rd_data), .flag(rd_flag)
    );
endmodule

// File: rtl/bmf_fifo_chk.sv
`timescale 1ns/1ps
module bmf_fifo_chk
    import bmf_pkg::*;
#(
    parameter int AW = 4
) (
    input logic        clk_a,
    input logic        clk_b,
    input logic        rst,
    input logic        fwft,
    input logic        wr_open,
    input logic [AW:0] wr_ptr,
    input logic [AW:0] rd_gray_a,
    input logic        rd_flag,
    input logic        rd_req,
    input logic [35:0] rd_data,
    input logic [1:0]  sub_idx,
    input port_width_e pw
);
    function automatic logic [AW:0] g2b(logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // R1: leaving reset the write side reports free space
    p_reset_open_r1: assert property (@(posedge clk_a) rst |=> wr_open);

    // R3: no pointer movement while full
    p_no_overflow_r3: assert property (@(posedge clk_a) disable iff (rst)
        !wr_open |=> $stable(wr_ptr));

    // R4: occupancy seen by the writer never exceeds the depth
    p_occupancy_r4: assert property (@(posedge clk_a) disable iff (rst)
        (wr_ptr - g2b(rd_gray_a)) <= (AW+1)'(1 << AW));

    // R5: piece position stays inside the selected width
    p_index_range_r5: assert property (@(posedge clk_b) disable iff (rst)
        sub_idx <= last_index(pw));

    // R8: fall-through output holds until consumed
    p_fwft_hold_r8: assert property (@(posedge clk_b) disable iff (rst)
        (fwft && rd_flag && !rd_req) |=> $stable(rd_data));

    // R9: standard output holds while nothing is stored
    p_empty_hold_r9: assert property (@(posedge clk_b) disable iff (rst)
        (!fwft && !rd_flag) |=> $stable(rd_data));
endmodule

bind bmf_fifo bmf_fifo_chk #(.AW(AW)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .fwft(fwft_mode),
    .wr_open(wr_open), .wr_ptr(wr_ptr), .rd_gray_a(rd_gray_a),
    .rd_flag(rd_flag), .rd_req(rd_req), .rd_data(rd_data),
    .sub_idx(sub_idx), .pw(pw)
);

// File: tb/bmf_fifo_test.sv
`timescale 1ns/1ps
module bmf_fifo_test;
    localparam int DEPTH = 16;

    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst = 1'b1;
    logic        fwft_mode = 1'b0;
    logic        wr_cs_n = 1'b1;
    logic        wr_dir = 1'b0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        wr_open;
    logic [1:0]  rd_width = 2'd0;
    logic        rd_cs_n = 1'b1;
    logic        rd_en = 1'b0;
    logic [35:0] rd_data;
    logic        rd_flag;

    int checks = 0;
    int failures = 0;
    int n_rd = 0;
    bit done = 1'b0;

    always #2.0 clk_a = ~clk_a;
    always #3.3 clk_b = ~clk_b;

    bmf_fifo #(.DEPTH(DEPTH)) uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .fwft_mode(fwft_mode),
        .wr_cs_n(wr_cs_n), .wr_dir(wr_dir), .wr_en(wr_en), .wr_data(wr_data),
        .wr_open(wr_open), .rd_width(rd_width), .rd_cs_n(rd_cs_n),
        .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag)
    );

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] pattern(int i, int cfg);
        return (36'(i) * 36'h1_1111_1111) ^ (36'(cfg) << 30) ^ 36'h0_00AB_CD05;
    endfunction

    function automatic logic [35:0] exp_piece(logic [35:0] w, int wsel, int k);
        if (wsel == 1) return (w >> (18 * k)) & 36'h0_0003_FFFF;
        if (wsel == 2) return (w >> (9 * k)) & 36'h0_0000_01FF;
        return w;
    endfunction

    task automatic read_next(int cfg, int wsel, int pieces, bit ff);
        logic [35:0] e;
        int g;
        e = exp_piece(pattern(n_rd / pieces, cfg), wsel, n_rd % pieces);
        g = 0;
        @(negedge clk_b);
        while (!rd_flag && g < 100) begin
            @(negedge clk_b);
            g++;
        end
        if (ff) check("R8 R5 R4 fall-through piece", rd_data, e);
        rd_cs_n = 1'b0;
        rd_en   = 1'b1;
        @(posedge clk_b);
        @(negedge clk_b);
        rd_cs_n = 1'b1;
        rd_en   = 1'b0;
        if (!ff) check("R7 R5 R4 standard piece", rd_data, e);
        n_rd++;
    endtask

    task automatic run_config(int wsel, bit ff);
        int cfg, pieces, cap, n_wr, guard, k_rel, cnt, found;
        logic [35:0] held;
        cfg    = int'(ff) * 3 + wsel;
        pieces = (wsel == 0) ? 1 : (wsel == 1 ? 2 : 4);
        cap    = (ff && wsel == 0) ? DEPTH + 1 : DEPTH;
        k_rel  = ff ? ((pieces == 1) ? 1 : pieces - 1) : pieces;
        n_rd   = 0;

        // reset with the new configuration applied
        @(negedge clk_a);
        rst = 1'b1;
        fwft_mode = ff;
        rd_width = 2'(wsel);
        repeat (4) @(posedge clk_b);
        repeat (4) @(posedge clk_a);
        @(negedge clk_a);
        check("R1 wr_open after reset", 36'(wr_open), 36'd1);
        check("R1 rd_flag after reset", 36'(rd_flag), 36'd0);
        check("R1 rd_data after reset", rd_data, 36'd0);
        rst = 1'b0;

        // R2: disqualified writes store nothing
        wr_en = 1'b1; wr_dir = 1'b0; wr_cs_n = 1'b0; wr_data = 36'h5_5555_5555;
        repeat (3) @(negedge clk_a);
        wr_dir = 1'b1; wr_cs_n = 1'b1;
        repeat (3) @(negedge clk_a);
        wr_en = 1'b0; wr_cs_n = 1'b0;
        repeat (8) @(negedge clk_b);
        check("R2 nothing stored by disqualified writes", 36'(rd_flag), 36'd0);

        // fill until the expected capacity is reached
        n_wr = 0;
        guard = 0;
        while (n_wr < cap && guard < 400) begin
            @(negedge clk_a);
            guard++;
            wr_en   = wr_open;
            wr_data = pattern(n_wr, cfg);
            if (wr_open) begin
                @(posedge clk_a);
                n_wr++;
            end
        end
        @(negedge clk_a);
        wr_en = 1'b0;
        check("R3 full on the filling edge", 36'(wr_open), 36'd0);
        check("R8 R3 capacity written", 36'(n_wr), 36'(cap));

        // overflow attempts are ignored
        wr_data = 36'hF_FFFF_FFFF;
        wr_en = 1'b1;
        repeat (3) @(negedge clk_a);
        wr_en = 1'b0;
        check("R3 still full after overflow attempt", 36'(wr_open), 36'd0);

        // R6: reads before the freeing one keep the writer blocked
        for (int i = 0; i < k_rel - 1; i++) read_next(cfg, wsel, pieces, ff);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_a);
            if (wr_open) cnt++;
        end
        check("R6 no release before last piece", 36'(cnt), 36'd0);

        read_next(cfg, wsel, pieces, ff);
        found = 99;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk_a);
            if (wr_open && found == 99) found = i;
        end
        check("R6 release after last piece", 36'(found <= 5), 36'd1);

        // one more write is accepted after release
        @(negedge clk_a);
        wr_en = 1'b1;
        wr_data = pattern(cap, cfg);
        @(posedge clk_a);
        @(negedge clk_a);
        wr_en = 1'b0;
        check("R2 R3 refill takes the freed slot", 36'(wr_open), 36'd0);

        // drain everything and compare order
        while (n_rd < (cap + 1) * pieces) read_next(cfg, wsel, pieces, ff);
        repeat (8) @(negedge clk_b);
        check("R4 nothing left after drain", 36'(rd_flag), 36'd0);

        if (!ff) begin
            held = rd_data;
            rd_cs_n = 1'b0;
            rd_en = 1'b1;
            repeat (3) @(negedge clk_b);
            rd_cs_n = 1'b1;
            rd_en = 1'b0;
            check("R9 empty read leaves data", rd_data, held);
            check("R9 empty read leaves flag low", 36'(rd_flag), 36'd0);
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 3; w++) run_config(w, m[0]);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule